// File: doc/BRIEF.md
# Edge Interval Capture Unit

This block measures the time between valid edges of an input pin and queues each measurement as a 16-bit tagged word. The pin first passes through a pulse-width filter. The unit counts in ticks of a programmable clock divider, and an edge mode picks which transitions end an interval. Software takes the words out of an eight-entry queue through a show-ahead read port.

Bit 15 of each word is a tag and bits 14:0 hold a width in ticks. In the rising-edge and falling-edge modes, a tag of 1 marks a partial chunk. Such a chunk is pushed each time the running count reaches the programmed end value before an edge arrives, and it adds to the next word whose tag is 0. In any-edge mode the tag gives the level that has just ended: 1 for a high phase and 0 for a low phase. The counter restarts from zero after every push. The first word after capture starts therefore measures from that start and not from an edge.

Three sticky flags report queue pressure, dropped words and end-value expiry. Each flag is cleared by writing 1 to its own clear bit. A clear-all control holds the counter and the queue empty, and it comes out of reset set.

Top module: `edge_gap_capture`

## Requirements
- R1: One tick occurs every `div` system clocks, with `div` = 0 meaning 4096. Widths are counted in ticks. An interval of 30 clocks at `div` = 3 reads as 0x000A.
- R2: With `mode` = 00, no word is pushed and the counter stays at zero, whatever the pin does.
- R3: `mode` = 11 pushes a word at each accepted rising edge and `mode` = 10 at each accepted falling edge. Both use tag 0, and the width is the number of ticks since the previous push, including the tick in the edge cycle.
- R4: `mode` = 01 pushes at every accepted level change. The tag is the level that just ended, so a high phase of 3 ticks reads 0x8003 and a low phase of 7 ticks reads 0x0007.
- R5: If the count reaches `end_val` on a tick with no edge in that cycle, the word {1, end_val[14:0]} is pushed, the count restarts and `tmo_flag` sets. With `end_val` = 0x4000, a 0x9035-tick interval yields 0xC000, 0xC000, 0x1035.
- R6: The counter is zero while capture is off (`cap_en` = 0, clear-all set, or `mode` = 00). The first word after capture starts counts from the first enabled clock.
- R7: A change on `cap_in` reaches `level` only after it has persisted for 4 ticks. When `bypass` = 1 and `div` = 1, `level` follows `cap_in` one clock later. `bypass` has no effect for any other `div`. `level` resets to 1.
- R8: The queue holds 8 words in arrival order. `fill` gives the count, `rd_data` shows the oldest word, or 0 when empty, and `rd_en` removes it. A read of an empty queue changes nothing.
- R9: A push into a full queue with no read in the same cycle is dropped and sets `ovf_flag`. Writing 1 to `flag_clr[1]` clears the flag.
- R10: `req_flag` sets on the clock after `fill` is 4 or more and stays set until `flag_clr[0]` is written as 1. A set condition in the same cycle wins over the clear. `flag_clr[2]` clears `tmo_flag`.
- R11: The clear-all bit (written by `clr_wr` with value `clr_din`) is 1 after reset. While it is 1, the queue empties, reads and pushes are ignored, and the counter stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | Capture pin, synchronous to clk |
| div | input | 12 | Tick divider, 0 means 4096 |
| end_val | input | 16 | Count end value for chunk words |
| mode | input | 2 | Edge mode: 00 off, 01 any, 10 falling, 11 rising |
| cap_en | input | 1 | Capture enable |
| bypass | input | 1 | Filter bypass, effective only when div is 1 |
| clr_wr | input | 1 | Write strobe for the clear-all bit |
| clr_din | input | 1 | Value written to the clear-all bit |
| rd_en | input | 1 | Remove the oldest queued word |
| flag_clr | input | 3 | Write-1 clears: [0] request, [1] overflow, [2] timeout |
| rd_data | output | 16 | Oldest queued word, 0 when empty |
| fill | output | 4 | Number of queued words |
| level | output | 1 | Filtered pin level |
| req_flag | output | 1 | Queue held 4 or more words |
| ovf_flag | output | 1 | A word was dropped |
| tmo_flag | output | 1 | A chunk word was generated |

## Verification
The hardest condition to reach is a chain of chunk words. It needs an interval longer than twice the end value, with no edge landing on the tick where the count meets the end value. The stimulus runs at a divider of 1 with the filter bypassed and places rising edges 0x456 and then 0x9035 clocks apart, so the expected chunks and remainder follow exactly from the clock count. Filter rejection depends on the tick phase, so the glitch tests use pulses that span at most two ticks and held levels that span at least four, whatever the phase.

// File: rtl/edge_gap_capture.sv
module edge_gap_capture #(
  parameter int DIV_W      = 12,
  parameter int CNT_W      = 16,
  parameter int FIFO_AW    = 3,
  parameter int REQ_LEVEL  = 4,
  parameter int FILT_TICKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_in,
  input  logic [DIV_W-1:0]   div,
  input  logic [CNT_W-1:0]   end_val,
  input  logic [1:0]         mode,
  input  logic               cap_en,
  input  logic               bypass,
  input  logic               clr_wr,
  input  logic               clr_din,
  input  logic               rd_en,
  input  logic [2:0]         flag_clr,
  output logic [CNT_W-1:0]   rd_data,
  output logic [FIFO_AW:0]   fill,
  output logic               level,
  output logic               req_flag,
  output logic               ovf_flag,
  output logic               tmo_flag
);

  localparam int DEPTH = 1 << FIFO_AW;
  localparam int FW    = $clog2(FILT_TICKS + 1);
  localparam logic [FIFO_AW:0] FULL_F = (FIFO_AW+1)'(DEPTH);
  localparam logic [FIFO_AW:0] REQ_F  = (FIFO_AW+1)'(REQ_LEVEL);

  logic [DIV_W-1:0] pre;
  logic             tick;
  assign tick = (pre == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + DIV_W'(1);

  logic [FW-1:0] fcnt;
  logic          byp_on, diff, acc;
  assign byp_on = bypass && (div == DIV_W'(1));
  assign diff   = cap_in ^ level;
  assign acc    = byp_on ? diff : (diff && tick && fcnt == FW'(FILT_TICKS-1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      level <= 1'b1;
      fcnt  <= '0;
    end else begin
      if (acc) level <= cap_in;
      if (!diff || acc || byp_on) fcnt <= '0;
      else if (tick)              fcnt <= fcnt + FW'(1);
    end

  logic             clr_q, run, vedge, tmo_hit, push;
  logic [CNT_W-1:0] cnt, inc, word;
  assign run     = cap_en && !clr_q && mode != 2'b00;
  assign vedge   = run && acc && (mode == 2'b01 || mode[0] == cap_in);
  assign inc     = cnt + CNT_W'(tick);
  assign tmo_hit = run && tick && !vedge &&
                   ({1'b0, cnt} + (CNT_W+1)'(1) == {1'b0, end_val});
  assign push    = vedge || tmo_hit;
  assign word    = vedge ? {(mode == 2'b01) ? level : 1'b0, inc[CNT_W-2:0]}
                         : {1'b1, end_val[CNT_W-2:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt <= '0;
    else if (!run || push) cnt <= '0;
    else if (tick)         cnt <= cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      clr_q <= 1'b1;
    else if (clr_wr) clr_q <= clr_din;

  logic [CNT_W-1:0]   mem [DEPTH];
  logic [FIFO_AW-1:0] wp, rp;
  logic               pop, drop, wr;
  assign pop  = rd_en && fill != '0 && !clr_q;
  assign drop = push && fill == FULL_F && !pop;
  assign wr   = push && !drop;

  always_ff @(posedge clk)
    if (wr) mem[wp] <= word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else if (clr_q) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else begin
      if (wr)  wp <= wp + FIFO_AW'(1);
      if (pop) rp <= rp + FIFO_AW'(1);
      fill <= fill + (FIFO_AW+1)'(wr) - (FIFO_AW+1)'(pop);
    end

  assign rd_data = (fill == '0) ? '0 : mem[rp];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_flag <= 1'b0; ovf_flag <= 1'b0; tmo_flag <= 1'b0;
    end else begin
      req_flag <= (req_flag && !flag_clr[0]) || (fill >= REQ_F);
      ovf_flag <= (ovf_flag && !flag_clr[1]) || drop;
      tmo_flag <= (tmo_flag && !flag_clr[2]) || tmo_hit;
    end

  p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_F);
  p_drop_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(fill) == FULL_F);
  p_req_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill >= REQ_F |=> req_flag);
  p_clear_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> fill == '0);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> fill <= $past(fill));
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && div == DIV_W'(1) && cap_in != level) |=> level == $past(cap_in));

endmodule

// File: tb/test_edge_gap_capture.sv
`timescale 1ns/1ps
module test_edge_gap_capture;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, cap_in = 1'b0, cap_en = 1'b0, bypass = 1'b0;
  logic        clr_wr = 1'b0, clr_din = 1'b0, rd_en = 1'b0;
  logic [11:0] div = 12'd1;
  logic [15:0] end_val = 16'h7FFF;
  logic [1:0]  mode = 2'b00;
  logic [2:0]  flag_clr = 3'b000;
  logic [15:0] rd_data;
  logic [3:0]  fill;
  logic        level, req_flag, ovf_flag, tmo_flag;

  edge_gap_capture i_edge_gap_capture (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .div(div), .end_val(end_val),
    .mode(mode), .cap_en(cap_en), .bypass(bypass), .clr_wr(clr_wr),
    .clr_din(clr_din), .rd_en(rd_en), .flag_clr(flag_clr), .rd_data(rd_data),
    .fill(fill), .level(level), .req_flag(req_flag), .ovf_flag(ovf_flag),
    .tmo_flag(tmo_flag));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int m_pre, m_fc, m_cnt, dv, old_size;
  bit m_lvl, m_clr, m_req, m_ovf, m_tmo, tk, byp, chg, accm, old_lvl, live, e_ok, t_hit, dropped;
  logic [15:0] w;
  logic [15:0] q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_fc = 0; m_cnt = 0; m_lvl = 1; m_clr = 1;
      m_req = 0; m_ovf = 0; m_tmo = 0; q.delete();
    end else begin
      dv = (div == 0) ? 4096 : int'(div);
      tk = (m_pre == dv - 1);
      byp = bypass && div == 1;
      chg = cap_in != m_lvl;
      accm = byp ? chg : (chg && tk && m_fc == 3);
      old_lvl = m_lvl;
      old_size = q.size();
      m_pre = tk ? 0 : m_pre + 1;
      if (!chg || accm || byp) m_fc = 0; else if (tk) m_fc++;
      if (accm) m_lvl = cap_in;
      live = cap_en && !m_clr && mode != 0;
      e_ok = live && accm && (mode == 1 || (mode == 3 && cap_in) || (mode == 2 && !cap_in));
      t_hit = live && tk && !e_ok && (m_cnt + 1 == int'(end_val));
      if (e_ok) w = {(mode == 1) ? old_lvl : 1'b0, 15'(m_cnt + int'(tk))};
      else      w = {1'b1, end_val[14:0]};
      if (!live || e_ok || t_hit) m_cnt = 0; else if (tk) m_cnt++;
      dropped = 0;
      if (m_clr) q.delete();
      else begin
        if (rd_en && q.size() > 0) void'(q.pop_front());
        if (e_ok || t_hit) begin
          if (q.size() < 8) q.push_back(w); else dropped = 1;
        end
      end
      m_req = (m_req && !flag_clr[0]) || old_size >= 4;
      m_ovf = (m_ovf && !flag_clr[1]) || dropped;
      m_tmo = (m_tmo && !flag_clr[2]) || t_hit;
      if (clr_wr) m_clr = clr_din;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R8 model fill", fill, q.size());
    chk("R3 model word", rd_data, (q.size() > 0) ? q[0] : 16'h0);
    chk("R7 model level", level, m_lvl);
    chk("R10 model req", req_flag, m_req);
    chk("R9 model ovf", ovf_flag, m_ovf);
    chk("R5 model tmo", tmo_flag, m_tmo);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [11:0] d, input logic b, input logic [15:0] e, input logic [1:0] m);
    rst_n = 0; cap_en = 0; cap_in = 0; rd_en = 0; flag_clr = 0;
    div = d; bypass = b; end_val = e; mode = m;
    step(2); rst_n = 1;
    clr_wr = 1; clr_din = 0; step(1); clr_wr = 0;
    step(20);
  endtask

  task automatic train(input int hi, input int lo, input int n);
    repeat (n) begin
      cap_in = 1; step(hi);
      cap_in = 0; step(lo);
    end
  endtask

  task automatic pop_expect(input string tag, input logic [15:0] exp);
    chk(tag, rd_data, exp);
    rd_en = 1; step(1); rd_en = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk("R11 reset fill", fill, 0);
    chk("R7 reset level", level, 1);
    chk("R10 reset flags", {req_flag, ovf_flag, tmo_flag}, 0);

    // R11: clear-all held after reset
    div = 1; bypass = 1; mode = 2'b01; cap_en = 1;
    train(3, 3, 3);
    chk("R11 held clear keeps queue empty", fill, 0);
    clr_wr = 1; clr_din = 0; step(1); clr_wr = 0;
    train(3, 3, 2);
    chk("R11 released clear queues words", fill, 4);
    clr_wr = 1; clr_din = 1; step(1); clr_wr = 0;
    step(1);
    chk("R11 clear-all empties queue", fill, 0);

    // R3 and R6: rising mode
    start(12'd1, 1'b1, 16'h7FFF, 2'b11);
    cap_en = 1; step(5);
    train(4, 6, 3);
    chk("R3 rising word count", fill, 3);
    pop_expect("R6 first word from enable", 16'h0006);
    pop_expect("R3 rising interval", 16'h000A);
    pop_expect("R3 rising interval second", 16'h000A);

    // R3 falling mode
    start(12'd1, 1'b1, 16'h7FFF, 2'b10);
    cap_en = 1; step(5);
    train(3, 7, 3);
    pop_expect("R6 first falling word", 16'h0009);
    pop_expect("R3 falling interval", 16'h000A);
    pop_expect("R3 falling interval second", 16'h000A);

    // R4 any-edge mode
    start(12'd1, 1'b1, 16'h7FFF, 2'b01);
    cap_en = 1; step(5);
    train(3, 7, 2);
    pop_expect("R4 initial low phase", 16'h0006);
    pop_expect("R4 high phase tag", 16'h8003);
    pop_expect("R4 low phase", 16'h0007);
    pop_expect("R4 high phase again", 16'h8003);

    // R1 divider, bypass ignored at div 3
    start(12'd3, 1'b1, 16'h7FFF, 2'b11);
    cap_en = 1; step(5);
    train(15, 15, 4);
    chk("R1 divided word count", fill, 4);
    rd_en = 1; step(1); rd_en = 0;
    pop_expect("R1 ticks of div 3", 16'h000A);
    pop_expect("R1 ticks of div 3 again", 16'h000A);
    // R7 glitch of 5 clocks spans at most 2 ticks
    cap_in = 1; step(5); cap_in = 0; step(12);
    chk("R7 short pulse rejected level", level, 0);
    chk("R7 short pulse pushes nothing", fill, 1);

    // R7 bypass versus filter at div 1
    start(12'd1, 1'b1, 16'h7FFF, 2'b00);
    cap_in = 1; step(1);
    chk("R7 bypass follows in one clock", level, 1);
    bypass = 0; cap_in = 0; step(1);
    chk("R7 filter holds old level", level, 1);
    step(3);
    chk("R7 filter accepts after 4 ticks", level, 0);

    // R2 mode 00 idle
    start(12'd1, 1'b1, 16'h7FFF, 2'b00);
    cap_en = 1;
    train(3, 3, 4);
    chk("R2 mode 00 pushes nothing", fill, 0);

    // R5 chunk chain, R10 request flag
    start(12'd1, 1'b1, 16'h4000, 2'b11);
    cap_en = 1; step(5);
    cap_in = 1; step(2); cap_in = 0; step(16'h0456 - 2);
    cap_in = 1; step(2); cap_in = 0; step(16'h9035 - 2);
    cap_in = 1; step(2); cap_in = 0;
    chk("R5 timeout flag", tmo_flag, 1);
    chk("R10 request flag with 5 words", req_flag, 1);
    pop_expect("R6 first word", 16'h0006);
    pop_expect("R5 short interval", 16'h0456);
    pop_expect("R5 first chunk", 16'hC000);
    pop_expect("R5 second chunk", 16'hC000);
    pop_expect("R5 remainder", 16'h1035);
    chk("R10 request flag sticky", req_flag, 1);
    flag_clr = 3'b101; step(1); flag_clr = 0;
    chk("R10 request flag cleared", req_flag, 0);
    chk("R10 timeout flag cleared", tmo_flag, 0);

    // R9 overflow and R8 ordering
    start(12'd1, 1'b1, 16'h7FFF, 2'b01);
    cap_en = 1; step(5);
    train(3, 3, 6);
    chk("R9 queue full", fill, 8);
    chk("R9 overflow flag", ovf_flag, 1);
    mode = 2'b00;
    flag_clr = 3'b010; step(1); flag_clr = 0;
    chk("R9 overflow cleared", ovf_flag, 0);
    pop_expect("R8 oldest word", 16'h0006);
    for (int i = 0; i < 7; i++)
      pop_expect("R8 arrival order", (i % 2 == 0) ? 16'h8003 : 16'h0003);
    chk("R8 empty reads zero", rd_data, 0);
    rd_en = 1; step(1); rd_en = 0;
    chk("R8 read of empty queue", fill, 0);

    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule